// File: doc/BRIEF.md
# Video Interrupt Pending and Acknowledge Controller

This block keeps the two interrupt pending flags of a video processor, one for the vertical (frame) interrupt and one for the horizontal (line) interrupt, and turns them into request lines for the CPU. The timing logic elsewhere in the video processor raises a one-cycle strobe when a frame or line event occurs. Each strobe sets its pending flag. A flag that is pending and enabled drives a request. When both requests could be active, only the vertical one is asserted.

The CPU acknowledge is simple on purpose. It does not know which interrupt the CPU is actually servicing. On each acknowledge pulse it looks at the pending flags and enable bits as they are at that moment, and it clears the one winning flag. If the enable bits changed after the CPU started its interrupt cycle, the flag that gets cleared can be a different one from the interrupt that was first raised. Acknowledge is only honoured when the extended display mode (mode 5) is selected. In legacy mode the acknowledge pulse is ignored.

Top module: `vid_irq_ctrl`

## Requirements
- R1: A synchronous active-high reset clears both pending flags, and both request outputs read 0 after the reset edge.
- R2: A vertical strobe sets the vertical pending flag at that clock edge. With the vertical enable on, `irq_vert_o` is 1 one clock edge later.
- R3: A horizontal strobe sets the horizontal pending flag at that clock edge. With the horizontal enable on and no vertical request, `irq_horz_o` is 1 one clock edge later.
- R4: A pending flag whose enable is off is kept. It raises its request one edge after its enable is turned on.
- R5: `irq_vert_o` and `irq_horz_o` are never 1 together. When both flags are pending and enabled, only `irq_vert_o` is 1.
- R6: In mode 5, if the vertical flag is pending and enabled when an acknowledge arrives, the acknowledge clears the vertical flag only.
- R7: In mode 5, if the vertical flag is not both pending and enabled when an acknowledge arrives, the acknowledge clears the horizontal flag, provided it is pending and enabled.
- R8: With mode 5 off, an acknowledge changes neither pending flag.
- R9: An acknowledge ignores which interrupt was first raised. A vertical flag that is pending but disabled is left alone, and an enabled horizontal flag is cleared in its place. If no flag is both pending and enabled, nothing is cleared.
- R10: If a set strobe and an acknowledge that would clear the same flag occur in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vert_set_i | input | 1 | Vertical event strobe, one cycle |
| horz_set_i | input | 1 | Horizontal event strobe, one cycle |
| vert_en_i | input | 1 | Vertical interrupt enable |
| horz_en_i | input | 1 | Horizontal interrupt enable |
| mode5_i | input | 1 | 1 selects mode 5, where acknowledge is honoured |
| ack_i | input | 1 | CPU interrupt acknowledge pulse |
| irq_vert_o | output | 1 | Registered vertical interrupt request |
| irq_horz_o | output | 1 | Registered horizontal interrupt request |

## Verification
The bench drives four groups of input patterns:
- Single strobes with the enables on and off. These separate how a flag is set from how it is gated, and show that a disabled flag is kept.
- Both flags pending under each enable combination. These show the vertical-first priority on the outputs.
- Acknowledges with mode 5 on and off, and with the vertical enable dropped between the strobe and the acknowledge. These show which flag an acknowledge removes, including the case where it removes the other flag, and that legacy mode removes nothing.
- A strobe that coincides with an acknowledge. This shows that setting wins over clearing.

// File: rtl/vid_irq_pkg.sv
package vid_irq_pkg;
  // Source index doubles as priority rank: lower index wins.
  localparam int unsigned SRC_VERT = 0;
  localparam int unsigned SRC_HORZ = 1;
  localparam int unsigned NUM_SRC  = 2;

  typedef struct packed {
    logic set;
    logic clr;
  } flag_ctl_t;
endpackage

// File: rtl/vid_irq_flag.sv
module vid_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  // Set has precedence over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst)        pend_o <= 1'b0;
    else if (set_i) pend_o <= 1'b1;
    else if (clr_i) pend_o <= 1'b0;
  end
endmodule

// File: rtl/vid_irq_ack_sel.sv
module vid_irq_ack_sel #(
  parameter int unsigned NSRC = 2
) (
  input  logic            ack_i,
  input  logic            mode5_i,
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] en_i,
  output logic [NSRC-1:0] clr_o
);
  logic [NSRC-1:0] live;
  logic [NSRC:0]   taken;

  assign live     = pend_i & en_i;
  assign taken[0] = 1'b0;

  // Clear the first live source in rank order; nothing outside mode 5.
  for (genvar g = 0; g < NSRC; g++) begin : g_rank
    assign clr_o[g]   = ack_i & mode5_i & live[g] & ~taken[g];
    assign taken[g+1] = taken[g] | live[g];
  end
endmodule

// File: rtl/vid_irq_req.sv
module vid_irq_req #(
  parameter int unsigned NSRC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] en_i,
  output logic [NSRC-1:0] req_o
);
  logic [NSRC-1:0] live;
  logic [NSRC:0]   above;
  logic [NSRC-1:0] req_d;

  assign live     = pend_i & en_i;
  assign above[0] = 1'b0;

  for (genvar g = 0; g < NSRC; g++) begin : g_pri
    assign req_d[g]   = live[g] & ~above[g];
    assign above[g+1] = above[g] | live[g];
  end

  always_ff @(posedge clk) begin
    if (rst) req_o <= '0;
    else     req_o <= req_d;
  end
endmodule

// File: rtl/vid_irq_ctrl.sv
module vid_irq_ctrl
  import vid_irq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic vert_set_i,
  input  logic horz_set_i,
  input  logic vert_en_i,
  input  logic horz_en_i,
  input  logic mode5_i,
  input  logic ack_i,
  output logic irq_vert_o,
  output logic irq_horz_o
);
  logic [NUM_SRC-1:0] set_v, en_v, clr_v, pend_q, req_q;
  flag_ctl_t          ctl [NUM_SRC];

  assign set_v[SRC_VERT] = vert_set_i;
  assign set_v[SRC_HORZ] = horz_set_i;
  assign en_v[SRC_VERT]  = vert_en_i;
  assign en_v[SRC_HORZ]  = horz_en_i;

  vid_irq_ack_sel #(.NSRC(NUM_SRC)) i_ack (
    .ack_i   (ack_i),
    .mode5_i (mode5_i),
    .pend_i  (pend_q),
    .en_i    (en_v),
    .clr_o   (clr_v)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
    assign ctl[g].set = set_v[g];
    assign ctl[g].clr = clr_v[g];
    vid_irq_flag i_flag (
      .clk    (clk),
      .rst    (rst),
      .set_i  (ctl[g].set),
      .clr_i  (ctl[g].clr),
      .pend_o (pend_q[g])
    );
  end

  vid_irq_req #(.NSRC(NUM_SRC)) i_req (
    .clk    (clk),
    .rst    (rst),
    .pend_i (pend_q),
    .en_i   (en_v),
    .req_o  (req_q)
  );

  assign irq_vert_o = req_q[SRC_VERT];
  assign irq_horz_o = req_q[SRC_HORZ];
endmodule

// File: rtl/vid_irq_chk.sv
module vid_irq_chk (
  input logic       clk,
  input logic       rst,
  input logic       vert_set_i,
  input logic       horz_set_i,
  input logic       vert_en_i,
  input logic       horz_en_i,
  input logic       mode5_i,
  input logic       ack_i,
  input logic       irq_vert_o,
  input logic       irq_horz_o,
  input logic [1:0] pend
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!irq_vert_o && !irq_horz_o && pend == 2'b00));

  a_r2_vert_sets: assert property (@(posedge clk) disable iff (rst)
    vert_set_i |=> pend[0]);

  a_r3_horz_sets: assert property (@(posedge clk) disable iff (rst)
    horz_set_i |=> pend[1]);

  a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(irq_vert_o && irq_horz_o));

  a_r6_ack_vert: assert property (@(posedge clk) disable iff (rst)
    (ack_i && mode5_i && pend[0] && vert_en_i && !vert_set_i && !horz_set_i)
      |=> (!pend[0] && $stable(pend[1])));

  a_r7_ack_horz: assert property (@(posedge clk) disable iff (rst)
    (ack_i && mode5_i && !(pend[0] && vert_en_i) && pend[1] && horz_en_i
     && !vert_set_i && !horz_set_i) |=> (!pend[1] && $stable(pend[0])));

  a_r8_legacy_ack: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !mode5_i && !vert_set_i && !horz_set_i) |=> $stable(pend));
endmodule

bind vid_irq_ctrl vid_irq_chk i_chk (
  .clk        (clk),
  .rst        (rst),
  .vert_set_i (vert_set_i),
  .horz_set_i (horz_set_i),
  .vert_en_i  (vert_en_i),
  .horz_en_i  (horz_en_i),
  .mode5_i    (mode5_i),
  .ack_i      (ack_i),
  .irq_vert_o (irq_vert_o),
  .irq_horz_o (irq_horz_o),
  .pend       (pend_q)
);

// File: tb/test_vid_irq_ctrl.sv
module test_vid_irq_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vs = 0, hs = 0, ve = 0, he = 0, m5 = 0, ack = 0;
  logic irq_v, irq_h;

  always #2.5 clk = ~clk;

  vid_irq_ctrl i_vid_irq_ctrl (
    .clk(clk), .rst(rst), .vert_set_i(vs), .horz_set_i(hs),
    .vert_en_i(ve), .horz_en_i(he), .mode5_i(m5), .ack_i(ack),
    .irq_vert_o(irq_v), .irq_horz_o(irq_h)
  );

  typedef struct {
    logic  v;
    logic  h;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_run = 0, n_fail = 0;
  logic mv = 0, mh = 0;  // expected pending state
  bit   done = 0;

  task automatic check(input string tag, input logic av, ah, ev, eh);
    n_run++;
    if (av !== ev || ah !== eh) begin
      n_fail++;
      $display("FAIL %s: irq v/h = %b%b, expected %b%b", tag, av, ah, ev, eh);
    end
  endtask

  // Drive one cycle of inputs and push the outputs the next edge must give.
  task automatic step(input logic s_v, s_h, e_v, e_h, mode, a, input string tag);
    exp_t e;
    logic live_v, cv, ch;
    @(negedge clk);
    vs = s_v; hs = s_h; ve = e_v; he = e_h; m5 = mode; ack = a;
    live_v = mv & e_v;
    e.v    = live_v;
    e.h    = mh & e_h & ~live_v;
    e.tag  = tag;
    cv = a & mode & live_v;
    ch = a & mode & ~live_v & mh & e_h;
    mv = s_v | (mv & ~cv);
    mh = s_h | (mh & ~ch);
    exp_q.push_back(e);
  endtask

  // Monitor: compare one cycle after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, irq_v, irq_h, e.v, e.h);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    vs = 1; hs = 1; ve = 1; he = 1;
    repeat (3) @(posedge clk);
    vs = 0; hs = 0;
    @(negedge clk);
    check("R1", irq_v, irq_h, 1'b0, 1'b0);
    rst = 0;
    step(0,0,1,1,1,0,"R1");

    // R2: vertical strobe, enabled
    step(1,0,1,1,1,0,"R2");
    step(0,0,1,1,1,0,"R2");
    step(0,0,1,1,1,0,"R2");
    // R6: ack clears vertical
    step(0,0,1,1,1,1,"R6");
    step(0,0,1,1,1,0,"R6");
    step(0,0,1,1,1,0,"R6");

    // R3: horizontal strobe, enabled
    step(0,1,1,1,1,0,"R3");
    step(0,0,1,1,1,0,"R3");
    step(0,0,1,1,1,0,"R3");
    // R7: ack clears horizontal
    step(0,0,1,1,1,1,"R7");
    step(0,0,1,1,1,0,"R7");

    // R4: pending with enable off is retained, request on enable
    step(1,1,0,0,1,0,"R4");
    step(0,0,0,0,1,0,"R4");
    step(0,0,0,0,1,0,"R4");
    step(0,0,0,1,1,0,"R4");
    step(0,0,0,1,1,0,"R4");
    // R5: both enabled, vertical only
    step(0,0,1,1,1,0,"R5");
    step(0,0,1,1,1,0,"R5");
    // R8: legacy-mode ack ignored
    step(0,0,1,1,0,1,"R8");
    step(0,0,1,1,0,1,"R8");
    step(0,0,1,1,1,0,"R8");
    step(0,0,1,1,1,0,"R8");
    // R9: vertical raised, but enable dropped before ack -> horizontal cleared
    step(0,0,0,1,1,1,"R9");
    step(0,0,1,1,1,0,"R9");
    step(0,0,1,1,1,0,"R9");
    step(0,0,1,1,1,1,"R6");
    step(0,0,1,1,1,0,"R6");
    // R9: nothing live -> nothing cleared
    step(1,1,0,0,1,0,"R9");
    step(0,0,0,0,1,1,"R9");
    step(0,0,1,1,1,0,"R9");
    step(0,0,1,1,1,0,"R9");
    step(0,0,1,1,1,1,"R9");
    step(0,0,1,1,1,1,"R9");
    step(0,0,1,1,1,0,"R9");

    // R10: set and ack together keep the flag
    step(1,0,1,1,1,0,"R10");
    step(1,0,1,1,1,1,"R10");
    step(0,0,1,1,1,0,"R10");
    step(0,0,1,1,1,0,"R10");
    step(0,1,1,1,1,0,"R10");
    step(0,1,1,1,1,1,"R10");
    step(0,0,1,1,1,0,"R10");
    step(0,0,1,1,1,0,"R10");

    // R1: reset mid-run clears everything
    step(1,1,1,1,1,0,"R1");
    @(negedge clk);
    rst = 1; vs = 0; hs = 0;
    @(posedge clk);
    exp_q.delete();
    @(negedge clk);
    check("R1", irq_v, irq_h, 1'b0, 1'b0);
    rst = 0; mv = 0; mh = 0;
    step(0,0,1,1,1,0,"R1");
    step(0,0,1,1,1,0,"R1");

    repeat (3) @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule